// File: doc/BRIEF.md
# Timer Compare Channel

This block is one 8-bit compare channel that sits next to a timer counter. Each time the counter advances, the channel checks whether the count equals its active compare value. On a hit it raises a sticky flag for the interrupt logic and moves a waveform pin as the 2-bit pin-action field selects. The counter, clock division and interrupt dispatch are outside the block. The counter supplies its value, a tick enable, top and bottom strobes and the waveform mode.

Software writes the compare value through a single write port. In the two PWM modes that write goes into a holding register. The active register takes the held value only at the point of the count sequence that the mode names, so a pulse can never come out short or uneven. In the two non-PWM modes the write reaches the active register at once. A software strobe can force a pin action without a real hit. A write to the counter arms a one-shot blanking of matches, so a counter loaded equal to the compare value does not fire.

Top module: `cmp_channel`

## Requirements
- R1: After reset the holding register, the active register, the flag and the pin are all zero.
- R2: In the non-PWM modes (`wave_mode` 00 free-running, 10 clear-on-compare), a `cmp_wr` updates both `cmp_active` and `cmp_rdata` on the next clock edge.
- R3: In the PWM modes (`wave_mode` 01 and 11), a `cmp_wr` updates only `cmp_rdata`. `cmp_active` keeps its value until the mode's load point.
- R4: In mode 01 the active register loads from the holding register on `at_top`. In mode 11 it loads on `at_bottom`. The other strobe has no effect.
- R5: `match_pulse` is high when `tick_en` is high, `cnt_val` equals `cmp_active` and blanking is not active. `match_flag` is set on the next edge.
- R6: `match_flag` stays set until a `flag_clr` cycle. A clear in the same cycle as a match leaves the flag set.
- R7: On a match the pin follows `out_mode`: 00 holds, 01 toggles, 10 drives low, 11 drives high.
- R8: In the non-PWM modes, `force_wr` applies the `out_mode` action to the pin on the next edge and leaves `match_flag` unchanged.
- R9: In the PWM modes, `force_wr` has no effect on the pin or the flag.
- R10: A `cnt_wr` blanks matches in its own cycle and through the first `tick_en` cycle that follows it. With `tick_en` low, blanking persists for any number of cycles.
- R11: No match occurs while `tick_en` is low, even when the count equals the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_mode | input | 2 | Waveform mode from the counter |
| tick_en | input | 1 | The counter advances (timer clock tick) this cycle |
| cnt_val | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at its top point |
| at_bottom | input | 1 | Counter is at its bottom point |
| cmp_wr | input | 1 | Software write of the compare value |
| cmp_wdata | input | 8 | Compare value to write |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| force_wr | input | 1 | Software force-compare strobe |
| out_mode | input | 2 | Pin action on match or force |
| flag_clr | input | 1 | Software clear of the match flag |
| cmp_rdata | output | 8 | Compare value as software reads it (holding register) |
| cmp_active | output | 8 | Active compare value used by the comparator |
| match_pulse | output | 1 | Qualified match event in this cycle |
| match_flag | output | 1 | Sticky match flag (interrupt request) |
| wave_out | output | 1 | Waveform pin |

## Verification
The assertions check the following on every cycle:
- a match always sets the flag;
- a clear with no match empties it;
- the active register stays still in PWM modes away from the load point;
- a counter write or a stopped clock never yields a match;
- a force never touches the flag, and does nothing in PWM modes.

Some behaviour only the bench's scenarios can show, because it depends on values built up over several cycles:
- the exact pin sequence through toggle, set, clear and hold;
- which strobe loads the buffer in each PWM mode;
- that blanking survives a long stop and lapses after exactly one tick.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic [1:0] {
    WM_FREE    = 2'b00,
    WM_PWM_TOP = 2'b01,
    WM_CLR_CMP = 2'b10,
    WM_PWM_BOT = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    PA_HOLD   = 2'b00,
    PA_TOGGLE = 2'b01,
    PA_LOW    = 2'b10,
    PA_HIGH   = 2'b11
  } pin_act_e;

  // PWM modes are the ones with bit 0 set
  function automatic logic mode_is_pwm(input logic [1:0] m);
    return m[0];
  endfunction

  // holding -> active transfer point for a PWM mode
  function automatic logic load_point(input logic [1:0] m,
                                      input logic top, input logic bot);
    logic r;
    case (m)
      WM_PWM_TOP: r = top;
      WM_PWM_BOT: r = bot;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  // next pin level for an action applied to the current level
  function automatic logic pin_next(input logic [1:0] act, input logic cur);
    logic r;
    case (act)
      PA_TOGGLE: r = ~cur;
      PA_LOW:    r = 1'b0;
      PA_HIGH:   r = 1'b1;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   wave_mode,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         at_top,
  input  logic         at_bottom,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] act_q
);
  logic pwm;
  logic load_evt;

  assign pwm      = mode_is_pwm(wave_mode);
  assign load_evt = pwm & load_point(wave_mode, at_top, at_bottom);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr) begin
      hold_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (!pwm && wr) begin
      act_q <= wdata;
    end else if (load_evt) begin
      act_q <= hold_q;
    end
  end
endmodule

// File: rtl/cmp_blank.sv
module cmp_blank (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_wr,
  input  logic tick_en,
  output logic blank
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (cnt_wr) begin
      armed_q <= 1'b1;
    end else if (tick_en) begin
      armed_q <= 1'b0;
    end
  end

  assign blank = armed_q | cnt_wr;
endmodule

// File: rtl/cmp_detect.sv
module cmp_detect #(
  parameter int W = 8
) (
  input  logic         tick_en,
  input  logic         blank,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] act,
  output logic         hit
);
  logic equal;

  assign equal = (cnt_val == act);
  assign hit   = tick_en & equal & ~blank;
endmodule

// File: rtl/cmp_pin.sv
module cmp_pin
  import cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       force_wr,
  input  logic [1:0] wave_mode,
  input  logic [1:0] out_mode,
  input  logic       flag_clr,
  output logic       flag_q,
  output logic       pin_q
);
  logic force_ok;
  logic act_now;

  assign force_ok = force_wr & ~mode_is_pwm(wave_mode);
  assign act_now  = hit | force_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (act_now) begin
      pin_q <= pin_next(out_mode, pin_q);
    end
  end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   wave_mode,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_val,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_wr,
  input  logic         force_wr,
  input  logic [1:0]   out_mode,
  input  logic         flag_clr,
  output logic [W-1:0] cmp_rdata,
  output logic [W-1:0] cmp_active,
  output logic         match_pulse,
  output logic         match_flag,
  output logic         wave_out
);
  logic blank;

  cmp_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode),
    .wr(cmp_wr), .wdata(cmp_wdata),
    .at_top(at_top), .at_bottom(at_bottom),
    .hold_q(cmp_rdata), .act_q(cmp_active)
  );

  cmp_blank blank_i (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr),
    .tick_en(tick_en), .blank(blank)
  );

  cmp_detect #(.W(W)) det_i (
    .tick_en(tick_en), .blank(blank), .cnt_val(cnt_val),
    .act(cmp_active), .hit(match_pulse)
  );

  cmp_pin pin_i (
    .clk(clk), .rst_n(rst_n), .hit(match_pulse), .force_wr(force_wr),
    .wave_mode(wave_mode), .out_mode(out_mode), .flag_clr(flag_clr),
    .flag_q(match_flag), .pin_q(wave_out)
  );
endmodule

// File: rtl/cmp_channel_chk.sv
module cmp_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   wave_mode,
  input logic         tick_en,
  input logic         at_top,
  input logic         at_bottom,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic         cnt_wr,
  input logic         force_wr,
  input logic [1:0]   out_mode,
  input logic         flag_clr,
  input logic [W-1:0] cmp_active,
  input logic         match_pulse,
  input logic         match_flag,
  input logic         wave_out
);
  logic pwm;
  logic at_load;

  assign pwm     = wave_mode[0];
  assign at_load = (wave_mode == 2'b01 && at_top) || (wave_mode == 2'b11 && at_bottom);

  AST_NONPWM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && cmp_wr) |=> cmp_active == $past(cmp_wdata)); // R2
  AST_PWM_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !at_load) |=> $stable(cmp_active)); // R3
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> match_flag); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_pulse) |=> !match_flag); // R6
  AST_PIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && out_mode == 2'b11) |=> wave_out); // R7
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wr && !match_pulse && !match_flag) |=> !match_flag); // R8
  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && force_wr && !match_pulse) |=> $stable(wave_out)); // R9
  AST_CNT_WR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !match_pulse); // R10
  AST_NO_TICK_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !match_pulse); // R11
endmodule

bind cmp_channel cmp_channel_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .tick_en(tick_en),
  .at_top(at_top), .at_bottom(at_bottom), .cmp_wr(cmp_wr),
  .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr), .force_wr(force_wr),
  .out_mode(out_mode), .flag_clr(flag_clr), .cmp_active(cmp_active),
  .match_pulse(match_pulse), .match_flag(match_flag), .wave_out(wave_out)
);

// File: tb/cmp_channel_tb_top.sv
module cmp_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wave_mode = 2'b00;
  logic       tick_en = 1'b0;
  logic [7:0] cnt_val = 8'h00;
  logic       at_top = 1'b0;
  logic       at_bottom = 1'b0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = 8'h00;
  logic       cnt_wr = 1'b0;
  logic       force_wr = 1'b0;
  logic [1:0] out_mode = 2'b00;
  logic       flag_clr = 1'b0;
  logic [7:0] cmp_rdata;
  logic [7:0] cmp_active;
  logic       match_pulse;
  logic       match_flag;
  logic       wave_out;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .tick_en(tick_en),
    .cnt_val(cnt_val), .at_top(at_top), .at_bottom(at_bottom),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr),
    .force_wr(force_wr), .out_mode(out_mode), .flag_clr(flag_clr),
    .cmp_rdata(cmp_rdata), .cmp_active(cmp_active),
    .match_pulse(match_pulse), .match_flag(match_flag), .wave_out(wave_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // one edge, then back to the falling edge for sampling and driving
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_wr = 1'b1; cmp_wdata = v; cyc(); cmp_wr = 1'b0;
  endtask

  task automatic tick_at(input logic [7:0] c);
    tick_en = 1'b1; cnt_val = c; cyc(); tick_en = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hold", cmp_rdata, 8'h00);
    chk("R1 active", cmp_active, 8'h00);
    chk("R1 flag", match_flag, 1'b0);
    chk("R1 pin", wave_out, 1'b0);
  endtask

  task automatic t_direct_write();
    wave_mode = 2'b00;
    wr_cmp(8'h40);
    chk("R2 active", cmp_active, 8'h40);
    chk("R2 rdata", cmp_rdata, 8'h40);
  endtask

  task automatic t_match_toggle();
    out_mode = 2'b01;
    tick_at(8'h41);
    chk("R5 no match on unequal", match_flag, 1'b0);
    tick_en = 1'b1; cnt_val = 8'h40; #1;
    chk("R5 pulse", match_pulse, 1'b1);
    @(negedge clk); tick_en = 1'b0;
    chk("R5 flag", match_flag, 1'b1);
    chk("R7 toggle up", wave_out, 1'b1);
    tick_at(8'h40);
    chk("R7 toggle down", wave_out, 1'b0);
  endtask

  task automatic t_flag();
    cyc();
    chk("R6 sticky", match_flag, 1'b1);
    clear_flag();
    chk("R6 cleared", match_flag, 1'b0);
    out_mode = 2'b00;
    flag_clr = 1'b1; tick_at(8'h40); flag_clr = 1'b0;
    chk("R6 match wins over clear", match_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_pin_modes();
    out_mode = 2'b11; tick_at(8'h40);
    chk("R7 set", wave_out, 1'b1);
    out_mode = 2'b00; tick_at(8'h40);
    chk("R7 hold", wave_out, 1'b1);
    out_mode = 2'b10; tick_at(8'h40);
    chk("R7 clear", wave_out, 1'b0);
    clear_flag();
  endtask

  task automatic t_no_tick();
    tick_en = 1'b0; cnt_val = 8'h40; #1;
    chk("R11 no pulse", match_pulse, 1'b0);
    cyc(); cyc();
    chk("R11 flag stays clear", match_flag, 1'b0);
  endtask

  task automatic t_force();
    out_mode = 2'b01; cnt_val = 8'h00;
    force_wr = 1'b1; cyc(); force_wr = 1'b0;
    chk("R8 pin toggled", wave_out, 1'b1);
    chk("R8 flag untouched", match_flag, 1'b0);
  endtask

  task automatic t_pwm_buffer();
    wave_mode = 2'b01;
    wr_cmp(8'h80);
    chk("R3 rdata", cmp_rdata, 8'h80);
    chk("R3 active held", cmp_active, 8'h40);
    at_bottom = 1'b1; cyc(); at_bottom = 1'b0;
    chk("R4 wrong strobe top-mode", cmp_active, 8'h40);
    at_top = 1'b1; cyc(); at_top = 1'b0;
    chk("R4 load at top", cmp_active, 8'h80);
    wave_mode = 2'b11;
    wr_cmp(8'h22);
    chk("R3 active held bot-mode", cmp_active, 8'h80);
    at_top = 1'b1; cyc(); at_top = 1'b0;
    chk("R4 wrong strobe bot-mode", cmp_active, 8'h80);
    at_bottom = 1'b1; cyc(); at_bottom = 1'b0;
    chk("R4 load at bottom", cmp_active, 8'h22);
  endtask

  task automatic t_pwm_force();
    out_mode = 2'b01; cnt_val = 8'h00;
    force_wr = 1'b1; cyc(); force_wr = 1'b0;
    chk("R9 pin unchanged", wave_out, 1'b1);
    chk("R9 flag unchanged", match_flag, 1'b0);
  endtask

  task automatic t_blank();
    wave_mode = 2'b00; out_mode = 2'b00;
    wr_cmp(8'h10);
    cnt_wr = 1'b1; cnt_val = 8'h10; cyc(); cnt_wr = 1'b0;
    for (int i = 0; i < 5; i++) cyc();
    tick_en = 1'b1; #1;
    chk("R10 blank after stop", match_pulse, 1'b0);
    @(negedge clk); tick_en = 1'b0;
    chk("R10 no flag", match_flag, 1'b0);
    tick_en = 1'b1; #1;
    chk("R10 blank lapses", match_pulse, 1'b1);
    @(negedge clk); tick_en = 1'b0;
    chk("R10 flag after lapse", match_flag, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_direct_write();
    t_match_toggle();
    t_flag();
    t_pin_modes();
    t_no_tick();
    t_force();
    t_pwm_buffer();
    t_pwm_force();
    t_blank();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule